// File: doc/BRIEF.md
# Arithmetic AES Byte Substitution Unit

This block performs the AES byte substitution and its inverse on a whole 128-bit state. It does this with arithmetic in the finite field GF(2^8) rather than with stored tables. Each byte lane inverts its byte in the field by raising it to the power 254. A squaring chain and a short chain of multipliers produce that power, and an affine map over GF(2) is then applied. One lane covers both directions. In the forward direction the inversion comes first and the forward affine map follows it. In the inverse direction the inverse affine map comes first and the inversion follows it.

The datapath is purely combinational, with no register between input and output. The stream interface is a pass-through valid/ready pair. A beat is transferred on any cycle in which `in_valid` and `out_ready` are both high. `out_valid` mirrors `in_valid` and `in_ready` mirrors `out_ready` in the same cycle, so back-pressure from the consumer reaches the producer with no delay and no storage. While a beat is stalled, the producer must hold `in_state` and `in_fwd` stable. The output then stays stable too.

Top module: `aes_subst_arith`

## Requirements
- R1: Field inversion uses the reduction polynomial x^8+x^4+x^3+x+1 (0x11B), and input 0x00 inverts to 0x00. In forward mode this makes every output byte equal the AES substitution value, for example 0x00 gives 0x63.
- R2: In forward mode, output bit i is the XOR of inverse bits i, i+4, i+5, i+6 and i+7 (all mod 8) with bit i of the constant 0x63. This gives 0x01 to 0x7C and 0x53 to 0xED.
- R3: In inverse mode, the byte first goes through the map whose bit i is the XOR of bits i+2, i+5 and i+7 (all mod 8) with bit i of 0x05, and is then inverted in the field. This gives 0x63 to 0x00, 0x7C to 0x01 and 0xED to 0x53.
- R4: Applying the inverse mode to the forward output returns the original byte for all 256 byte values.
- R5: `in_fwd` = 1 selects the forward substitution and `in_fwd` = 0 selects the inverse. Both directions come from the same lane hardware.
- R6: Output byte k (bits 8k+7 down to 8k) depends only on input byte k. Lane 0 is bits 7:0.
- R7: `out_valid` equals `in_valid` in the same cycle, with no register in the path.
- R8: `in_ready` equals `out_ready` in the same cycle, so a consumer stall stalls the producer at once.
- R9: In forward mode, no output byte equals its input byte or the bitwise complement of its input byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Producer has a state beat |
| in_ready | output | 1 | Unit can accept the beat (equals out_ready) |
| in_fwd | input | 1 | 1 = forward substitution, 0 = inverse |
| in_state | input | 128 | Input state, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Substituted beat available (equals in_valid) |
| out_ready | input | 1 | Consumer accepts the beat |
| out_state | output | 128 | Substituted state, byte k at bits 8k+7:8k |

## Verification
A sweep packs all 256 byte values into 16 forward beats and compares them with a table. The bench builds that table by brute-force search for field inverses and by the affine formula, and the sweep separates a wrong reduction polynomial, a wrong constant or a wrong rotation in the affine map. The forward outputs are then fed back through the inverse mode, which shows any flaw in the inverse affine map or in the direction mux. A single known byte is walked across lanes that are otherwise zero, which exposes lane crossing or swapping. Random beats, with random valid and ready levels, check the mixed-byte states and show that the handshake mirrors its inputs in the same cycle.

// File: rtl/aes_subst_pkg.sv
package aes_subst_pkg;
  localparam int BYTE_W = 8;
  localparam int INV_STEPS = BYTE_W - 1;
  localparam logic [BYTE_W-1:0] RED_POLY  = 8'h1B;
  localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;

  typedef logic [BYTE_W-1:0] gf_byte_t;

  function automatic gf_byte_t gf_xtime(gf_byte_t a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
  endfunction

  // Squaring is linear over GF(2); computed by a shift-and-add loop.
  function automatic gf_byte_t gf_square(gf_byte_t a);
    gf_byte_t acc;
    gf_byte_t run;
    acc = '0;
    run = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (a[i]) acc = acc ^ run;
      run = gf_xtime(run);
    end
    return acc;
  endfunction
endpackage

// File: rtl/gf_mul8.sv
module gf_mul8
  import aes_subst_pkg::*;
(
  input  gf_byte_t a,
  input  gf_byte_t b,
  output gf_byte_t p
);
  gf_byte_t pw [BYTE_W];
  gf_byte_t term [BYTE_W];

  assign pw[0] = a;
  for (genvar k = 1; k < BYTE_W; k++) begin : g_pow
    assign pw[k] = gf_xtime(pw[k-1]);
  end
  for (genvar k = 0; k < BYTE_W; k++) begin : g_term
    assign term[k] = b[k] ? pw[k] : '0;
  end

  always_comb begin
    p = '0;
    for (int k = 0; k < BYTE_W; k++) p = p ^ term[k];
  end
endmodule

// File: rtl/gf_inv8.sv
module gf_inv8
  import aes_subst_pkg::*;
(
  input  gf_byte_t x,
  output gf_byte_t y
);
  // y = x^254 = x^2 * x^4 * ... * x^128 ; zero maps to zero naturally
  gf_byte_t sq  [1:INV_STEPS];
  gf_byte_t acc [1:INV_STEPS];

  assign sq[1]  = gf_square(x);
  assign acc[1] = sq[1];
  for (genvar k = 2; k <= INV_STEPS; k++) begin : g_chain
    assign sq[k] = gf_square(sq[k-1]);
    gf_mul8 u_mul (.a(acc[k-1]), .b(sq[k]), .p(acc[k]));
  end
  assign y = acc[INV_STEPS];
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
  import aes_subst_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  gf_byte_t x,
  output gf_byte_t y
);
  if (!INVERSE) begin : g_fwd
    always_comb begin
      for (int i = 0; i < BYTE_W; i++)
        y[i] = x[i] ^ x[(i+4)%BYTE_W] ^ x[(i+5)%BYTE_W] ^ x[(i+6)%BYTE_W]
             ^ x[(i+7)%BYTE_W] ^ FWD_CONST[i];
    end
  end else begin : g_inv
    always_comb begin
      for (int i = 0; i < BYTE_W; i++)
        y[i] = x[(i+2)%BYTE_W] ^ x[(i+5)%BYTE_W] ^ x[(i+7)%BYTE_W] ^ INV_CONST[i];
    end
  end
endmodule

// File: rtl/sbox_lane.sv
module sbox_lane
  import aes_subst_pkg::*;
(
  input  logic     fwd,
  input  gf_byte_t din,
  output gf_byte_t dout
);
  gf_byte_t pre_inv, field_in, field_out, post_fwd;

  sbox_affine #(.INVERSE(1'b1)) u_aff_inv (.x(din), .y(pre_inv));
  assign field_in = fwd ? din : pre_inv;
  gf_inv8 u_inv (.x(field_in), .y(field_out));
  sbox_affine #(.INVERSE(1'b0)) u_aff_fwd (.x(field_out), .y(post_fwd));
  assign dout = fwd ? post_fwd : field_out;
endmodule

// File: rtl/aes_subst_arith.sv
module aes_subst_arith
  import aes_subst_pkg::*;
#(
  parameter  int LANES   = 16,
  localparam int STATE_W = LANES * BYTE_W
) (
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_fwd,
  input  logic [STATE_W-1:0] in_state,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [STATE_W-1:0] out_state
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sbox_lane u_lane (
      .fwd  (in_fwd),
      .din  (in_state[k*BYTE_W +: BYTE_W]),
      .dout (out_state[k*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/aes_subst_arith_chk.sv
module aes_subst_arith_chk
  import aes_subst_pkg::*;
#(
  parameter  int LANES   = 16,
  localparam int STATE_W = LANES * BYTE_W
) (
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_fwd,
  input logic [STATE_W-1:0] in_state,
  input logic               out_valid,
  input logic               out_ready,
  input logic [STATE_W-1:0] out_state
);
  always_comb begin
    if (!$isunknown({in_valid, out_valid}))
      // R7
      valid_follow_chk: assert (out_valid == in_valid) else $error("valid not mirrored");
    if (!$isunknown({in_ready, out_ready}))
      // R8
      ready_follow_chk: assert (in_ready == out_ready) else $error("ready not mirrored");
    if (!$isunknown({in_fwd, in_state, out_state})) begin
      for (int k = 0; k < LANES; k++) begin
        if (in_fwd) begin
          // R9
          no_fixed_point_chk: assert (out_state[k*BYTE_W +: BYTE_W] != in_state[k*BYTE_W +: BYTE_W]
                                   && out_state[k*BYTE_W +: BYTE_W] != ~in_state[k*BYTE_W +: BYTE_W])
            else $error("fixed point in lane %0d", k);
          if (in_state[k*BYTE_W +: BYTE_W] == 8'h00)
            // R1
            zero_fwd_chk: assert (out_state[k*BYTE_W +: BYTE_W] == 8'h63) else $error("zero fwd lane %0d", k);
        end else if (in_state[k*BYTE_W +: BYTE_W] == 8'h63) begin
          // R3
          zero_inv_chk: assert (out_state[k*BYTE_W +: BYTE_W] == 8'h00) else $error("zero inv lane %0d", k);
        end
      end
    end
  end
endmodule

bind aes_subst_arith aes_subst_arith_chk #(.LANES(LANES)) u_chk (
  .in_valid(in_valid), .in_ready(in_ready), .in_fwd(in_fwd), .in_state(in_state),
  .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state)
);

// File: tb/aes_subst_arith_tb.sv
`timescale 1ns/1ps
module aes_subst_arith_tb;
  localparam int LANES = 16;
  localparam int SW = LANES * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid, in_ready, in_fwd, out_valid, out_ready;
  logic [SW-1:0] in_state, out_state;

  aes_subst_arith #(.LANES(LANES)) u_dut (
    .in_valid(in_valid), .in_ready(in_ready), .in_fwd(in_fwd), .in_state(in_state),
    .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] fwd_tab [256];

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_finv(logic [7:0] a);
    for (int c = 1; c < 256; c++)
      if (ref_mul(a, 8'(c)) == 8'h01) return 8'(c);
    return 8'h00;
  endfunction

  function automatic logic [7:0] ref_fwd(logic [7:0] x);
    logic [7:0] b = ref_finv(x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return y;
  endfunction

  function automatic logic [7:0] ref_inv(logic [7:0] y);
    for (int c = 0; c < 256; c++)
      if (fwd_tab[c] == y) return 8'(c);
    return 8'hXX;
  endfunction

  function automatic logic [SW-1:0] exp_state(logic [SW-1:0] s, logic fwd);
    logic [SW-1:0] r;
    for (int k = 0; k < LANES; k++)
      r[k*8 +: 8] = fwd ? fwd_tab[s[k*8 +: 8]] : ref_inv(s[k*8 +: 8]);
    return r;
  endfunction

  task automatic check(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [SW-1:0] s, logic fwd, logic v, logic rdy);
    @(posedge clk);
    in_state = s; in_fwd = fwd; in_valid = v; out_ready = rdy;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] s, fo;
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 256; c++) fwd_tab[c] = ref_fwd(8'(c));
    in_valid = 0; out_ready = 0; in_fwd = 1; in_state = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle out_valid", SW'(out_valid), SW'(0));
    check("R8 idle in_ready", SW'(in_ready), SW'(0));

    // R1 R2: directed forward vectors
    apply({8'h53, 8'h01, 8'h00, {(LANES-3){8'h00}}}, 1'b1, 1'b1, 1'b1);
    check("R2 fwd 53/01/00", out_state, {8'hED, 8'h7C, 8'h63, {(LANES-3){8'h63}}});
    // R3: directed inverse vectors, R5 same unit other direction
    apply({8'hED, 8'h7C, {(LANES-2){8'h63}}}, 1'b0, 1'b1, 1'b1);
    check("R3 inv ED/7C/63", out_state, {8'h53, 8'h01, {(LANES-2){8'h00}}});

    // R1: full forward sweep, 16 beats
    for (int b = 0; b < 256 / LANES; b++) begin
      for (int k = 0; k < LANES; k++) s[k*8 +: 8] = 8'(b * LANES + k);
      apply(s, 1'b1, 1'b1, 1'b1);
      fo = out_state;
      check("R1 fwd sweep", fo, exp_state(s, 1'b1));
      // R4: round trip through inverse mode
      apply(fo, 1'b0, 1'b1, 1'b1);
      check("R4 round trip", out_state, s);
      // R9: no fixed or complement point
      for (int k = 0; k < LANES; k++) begin
        checks++;
        if (fo[k*8 +: 8] == s[k*8 +: 8] || fo[k*8 +: 8] == ~s[k*8 +: 8]) begin
          errors++;
          $display("FAIL R9: actual=%h expected!=%h", fo[k*8 +: 8], s[k*8 +: 8]);
        end
      end
    end

    // R6: walk one byte across otherwise zero lanes
    for (int k = 0; k < LANES; k++) begin
      s = '0;
      s[k*8 +: 8] = 8'h53;
      apply(s, 1'b1, 1'b1, 1'b1);
      check("R6 lane walk", out_state, exp_state(s, 1'b1));
    end

    // R5 R7 R8: random beats, random direction and handshake levels
    for (int n = 0; n < 200; n++) begin
      logic fwd, v, r;
      for (int w = 0; w < SW / 32; w++) s[w*32 +: 32] = $urandom;
      fwd = 1'($urandom); v = 1'($urandom); r = 1'($urandom);
      apply(s, fwd, v, r);
      check("R5 random", out_state, exp_state(s, fwd));
      check("R7 valid", SW'(out_valid), SW'(v));
      check("R8 ready", SW'(in_ready), SW'(r));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule